// File: doc/BRIEF.md
# LIN Master Transmit-Path Byte Sequencer

This block sits between a byte-wide transmit holding register and the frame engine of a serial controller running as a LIN master. It decides where each byte written by a DMA channel goes. When in-band configuration is enabled, each frame opens with two configuration bytes. The first holds the node action and the frame option flags. The second holds the data-length count. A publishing node then sends an identifier byte, followed by the payload bytes. When in-band configuration is disabled, the frame options, length and action come from static software inputs, and the first written byte of each frame is the identifier.

The block paces the DMA with two byte-level ready flags, one for transmit and one for receive. When the header is complete, it pulses a frame-start strobe and holds the frame fields steady for the engine. It passes payload bytes to the engine over a valid/ready stream. For a subscribing frame, it delivers the received bytes through a one-byte receive holding register. Bit timing, break and synch generation, and checksums are left to the engine.

Top module: `lin_hdr_seq`

## Requirements
- R1: After a synchronous reset, txrdy is 1, tx_ovr, pl_vld, frame_go and rxrdy are 0, and the next written byte is treated as the first header byte of a frame.
- R2: A write accepted while txrdy is 1 drops txrdy in the following cycle. For a header byte, txrdy is back to 1 one cycle later.
- R3: A write while txrdy is 0 is ignored: it reaches neither the payload stream nor the header. It sets tx_ovr, which stays 1 until reset.
- R4: With cfg_dma_en = 1, configuration byte 1 is decoded as follows: node action in bits [1:0] (PUBLISH = 0, SUBSCRIBE = 1, IGNORE = 2, 3 treated as IGNORE), parity disable in bit 2, checksum disable in bit 3, checksum type in bit 4, length mode in bit 5, frame-slot disable in bit 6. Configuration byte 2 is the data-length count.
- R5: With cfg_dma_en = 1 and action PUBLISH, the third byte of the frame is the identifier. frame_go pulses for one cycle, in the cycle after that byte is taken, and the fr_* outputs then show the decoded fields.
- R6: A PUBLISH frame carries data-length count + 1 payload bytes on pl_data. Each byte is held with pl_vld until pl_rdy. After the last payload byte, the next written byte is configuration byte 1 again.
- R7: With cfg_dma_en = 1 and action SUBSCRIBE or IGNORE, frame_go pulses in the cycle after configuration byte 2 is taken, and fr_ident takes sw_ident. An IGNORE frame produces no payload, and its next written byte is configuration byte 1.
- R8: With cfg_dma_en = 0, the first written byte of a frame is the identifier. The fields and length come from sw_mode (same bit layout as R4) and sw_dlc, and a PUBLISH frame then carries sw_dlc + 1 payload bytes.
- R9: After a SUBSCRIBE header, txrdy stays 0 until data-length count + 1 bytes have arrived on rx_vld. Each arriving byte is loaded into rhr_data and sets rxrdy. rhr_rd clears rxrdy, unless a new byte arrives in the same cycle, in which case rxrdy stays 1 with the new byte.
- R10: A byte arriving on rx_vld outside a subscribing frame is dropped: rxrdy and rhr_data keep their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_dma_en | input | 1 | 1: frame configuration arrives in-band; 0: taken from sw_* |
| sw_mode | input | 8 | Software frame options, layout of configuration byte 1 |
| sw_dlc | input | 8 | Software data-length count |
| sw_ident | input | 8 | Identifier used when none is carried in the stream |
| thr_wr | input | 1 | DMA write strobe to the transmit holding register |
| thr_data | input | 8 | DMA write byte |
| txrdy | output | 1 | Transmit ready, paces DMA writes |
| tx_ovr | output | 1 | Sticky: a write arrived while txrdy was 0 |
| pl_vld | output | 1 | Payload byte valid |
| pl_data | output | 8 | Payload byte |
| pl_rdy | input | 1 | Engine takes the payload byte |
| frame_go | output | 1 | One-cycle pulse when a frame header is complete |
| fr_act | output | 2 | Node action of the current frame |
| fr_pardis | output | 1 | Parity disable |
| fr_chkdis | output | 1 | Checksum disable |
| fr_chktyp | output | 1 | Checksum type |
| fr_dlm | output | 1 | Length mode |
| fr_fsdis | output | 1 | Frame-slot disable |
| fr_dlc | output | 8 | Data-length count |
| fr_ident | output | 8 | Identifier |
| rx_vld | input | 1 | Received byte valid from the engine |
| rx_data | input | 8 | Received byte |
| rxrdy | output | 1 | Receive holding register full, paces DMA reads |
| rhr_data | output | 8 | Receive holding register |
| rhr_rd | input | 1 | DMA read strobe of the receive holding register |

## Verification
In a subscribing frame, a new received byte can land in the same cycle that the DMA reads the previous one. The bench provokes this by raising rx_vld and rhr_rd together. It then expects rxrdy to stay set with the second byte in rhr_data, and txrdy to return as the final byte of the count lands. On the transmit side, a payload byte stalled by pl_rdy = 0 can meet a DMA write that arrives while txrdy is low. The bench drives that blocked write and judges it by the sticky overrun flag, the unchanged stalled byte, and a scoreboard that must never see the dropped byte.

// File: rtl/lin_hdr_pkg.sv
package lin_hdr_pkg;

    typedef enum logic [1:0] {
        ACT_PUB = 2'd0,
        ACT_SUB = 2'd1,
        ACT_IGN = 2'd2,
        ACT_RSV = 2'd3
    } lin_act_e;

    // Frame option fields, packed to match the first configuration byte bits [6:0]
    typedef struct packed {
        logic     fsdis;
        logic     dlm;
        logic     chktyp;
        logic     chkdis;
        logic     pardis;
        lin_act_e act;
    } lin_mode_t;

    localparam int MODE_W = $bits(lin_mode_t);

    typedef enum logic [2:0] {
        SQ_HEAD1,
        SQ_HEAD2,
        SQ_IDENT,
        SQ_PAYLD,
        SQ_SUBRX
    } seq_st_e;

    function automatic lin_mode_t decode_mode(input logic [7:0] b);
        return lin_mode_t'(b[MODE_W-1:0]);
    endfunction

    // State entered once the header of a frame is complete
    function automatic seq_st_e after_header(input lin_act_e a);
        case (a)
            ACT_PUB: return SQ_PAYLD;
            ACT_SUB: return SQ_SUBRX;
            default: return SQ_HEAD1;
        endcase
    endfunction

endpackage

// File: rtl/lin_txbuf.sv
module lin_txbuf #(
    parameter int DW = 8
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          wr,
    input  logic [DW-1:0] wdata,
    input  logic          consume,
    input  logic          hold_off,
    output logic          full,
    output logic [DW-1:0] bdata,
    output logic          txrdy,
    output logic          ovr
);
    logic          full_q;
    logic [DW-1:0] data_q;
    logic          ovr_q;
    logic          accept;

    assign txrdy  = !full_q && !hold_off;
    assign accept = wr && txrdy;

    always_ff @(posedge clk) begin
        if (rst) begin
            full_q <= 1'b0;
            data_q <= '0;
            ovr_q  <= 1'b0;
        end else begin
            if (accept) begin
                full_q <= 1'b1;
                data_q <= wdata;
            end else if (consume) begin
                full_q <= 1'b0;
            end
            if (wr && !txrdy) ovr_q <= 1'b1;
        end
    end

    assign full  = full_q;
    assign bdata = data_q;
    assign ovr   = ovr_q;
endmodule

// File: rtl/lin_hdr_fsm.sv
module lin_hdr_fsm
    import lin_hdr_pkg::*;
#(
    parameter int DW = 8
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          dma_mode,
    input  logic [DW-1:0] sw_mode,
    input  logic [DW-1:0] sw_dlc,
    input  logic [DW-1:0] sw_ident,
    input  logic          buf_full,
    input  logic [DW-1:0] buf_data,
    input  logic          pl_rdy,
    input  logic          rx_vld,
    output logic          consume,
    output logic          sub_active,
    output logic          pl_vld,
    output logic          frame_go,
    output lin_mode_t     mode_o,
    output logic [DW-1:0] dlc_o,
    output logic [DW-1:0] ident_o
);
    seq_st_e       st_q;
    lin_mode_t     mode_q;
    lin_mode_t     sw_fields;
    logic [DW-1:0] dlc_q;
    logic [DW-1:0] ident_q;
    logic [DW-1:0] left_q;
    logic          go_q;

    assign sw_fields  = decode_mode(sw_mode[7:0]);
    assign sub_active = (st_q == SQ_SUBRX);
    assign pl_vld     = buf_full && (st_q == SQ_PAYLD);
    assign consume    = buf_full && !sub_active && ((st_q != SQ_PAYLD) || pl_rdy);

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q    <= SQ_HEAD1;
            mode_q  <= '0;
            dlc_q   <= '0;
            ident_q <= '0;
            left_q  <= '0;
            go_q    <= 1'b0;
        end else begin
            go_q <= 1'b0;
            case (st_q)
                SQ_HEAD1: if (consume) begin
                    if (dma_mode) begin
                        mode_q <= decode_mode(buf_data[7:0]);
                        st_q   <= SQ_HEAD2;
                    end else begin
                        mode_q  <= sw_fields;
                        dlc_q   <= sw_dlc;
                        left_q  <= sw_dlc;
                        ident_q <= buf_data;
                        go_q    <= 1'b1;
                        st_q    <= after_header(sw_fields.act);
                    end
                end
                SQ_HEAD2: if (consume) begin
                    dlc_q  <= buf_data;
                    left_q <= buf_data;
                    if (mode_q.act == ACT_PUB) begin
                        st_q <= SQ_IDENT;
                    end else begin
                        ident_q <= sw_ident;
                        go_q    <= 1'b1;
                        st_q    <= after_header(mode_q.act);
                    end
                end
                SQ_IDENT: if (consume) begin
                    ident_q <= buf_data;
                    go_q    <= 1'b1;
                    st_q    <= SQ_PAYLD;
                end
                SQ_PAYLD: if (consume) begin
                    if (left_q == '0) st_q <= SQ_HEAD1;
                    else              left_q <= left_q - 1'b1;
                end
                SQ_SUBRX: if (rx_vld) begin
                    if (left_q == '0) st_q <= SQ_HEAD1;
                    else              left_q <= left_q - 1'b1;
                end
                default: st_q <= SQ_HEAD1;
            endcase
        end
    end

    assign frame_go = go_q;
    assign mode_o   = mode_q;
    assign dlc_o    = dlc_q;
    assign ident_o  = ident_q;
endmodule

// File: rtl/lin_rxbuf.sv
module lin_rxbuf #(
    parameter int DW = 8
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          rx_vld,
    input  logic [DW-1:0] rx_data,
    input  logic          take_en,
    input  logic          rd,
    output logic          rdy,
    output logic [DW-1:0] hold
);
    logic          rdy_q;
    logic [DW-1:0] hold_q;
    logic          take;

    assign take = rx_vld && take_en;

    always_ff @(posedge clk) begin
        if (rst) begin
            rdy_q  <= 1'b0;
            hold_q <= '0;
        end else if (take) begin
            rdy_q  <= 1'b1;
            hold_q <= rx_data;
        end else if (rd) begin
            rdy_q  <= 1'b0;
        end
    end

    assign rdy  = rdy_q;
    assign hold = hold_q;
endmodule

// File: rtl/lin_hdr_seq.sv
module lin_hdr_seq
    import lin_hdr_pkg::*;
#(
    parameter int DW = 8
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          cfg_dma_en,
    input  logic [DW-1:0] sw_mode,
    input  logic [DW-1:0] sw_dlc,
    input  logic [DW-1:0] sw_ident,
    input  logic          thr_wr,
    input  logic [DW-1:0] thr_data,
    output logic          txrdy,
    output logic          tx_ovr,
    output logic          pl_vld,
    output logic [DW-1:0] pl_data,
    input  logic          pl_rdy,
    output logic          frame_go,
    output logic [1:0]    fr_act,
    output logic          fr_pardis,
    output logic          fr_chkdis,
    output logic          fr_chktyp,
    output logic          fr_dlm,
    output logic          fr_fsdis,
    output logic [DW-1:0] fr_dlc,
    output logic [DW-1:0] fr_ident,
    input  logic          rx_vld,
    input  logic [DW-1:0] rx_data,
    output logic          rxrdy,
    output logic [DW-1:0] rhr_data,
    input  logic          rhr_rd
);
    logic          buf_full;
    logic [DW-1:0] buf_data;
    logic          consume;
    logic          sub_active;
    lin_mode_t     mode;

    lin_txbuf #(.DW(DW)) u_txbuf (
        .clk      (clk),
        .rst      (rst),
        .wr       (thr_wr),
        .wdata    (thr_data),
        .consume  (consume),
        .hold_off (sub_active),
        .full     (buf_full),
        .bdata    (buf_data),
        .txrdy    (txrdy),
        .ovr      (tx_ovr)
    );

    lin_hdr_fsm #(.DW(DW)) u_fsm (
        .clk        (clk),
        .rst        (rst),
        .dma_mode   (cfg_dma_en),
        .sw_mode    (sw_mode),
        .sw_dlc     (sw_dlc),
        .sw_ident   (sw_ident),
        .buf_full   (buf_full),
        .buf_data   (buf_data),
        .pl_rdy     (pl_rdy),
        .rx_vld     (rx_vld),
        .consume    (consume),
        .sub_active (sub_active),
        .pl_vld     (pl_vld),
        .frame_go   (frame_go),
        .mode_o     (mode),
        .dlc_o      (fr_dlc),
        .ident_o    (fr_ident)
    );

    lin_rxbuf #(.DW(DW)) u_rxbuf (
        .clk     (clk),
        .rst     (rst),
        .rx_vld  (rx_vld),
        .rx_data (rx_data),
        .take_en (sub_active),
        .rd      (rhr_rd),
        .rdy     (rxrdy),
        .hold    (rhr_data)
    );

    assign pl_data   = buf_data;
    assign fr_act    = mode.act;
    assign fr_pardis = mode.pardis;
    assign fr_chkdis = mode.chkdis;
    assign fr_chktyp = mode.chktyp;
    assign fr_dlm    = mode.dlm;
    assign fr_fsdis  = mode.fsdis;
endmodule

// File: rtl/lin_hdr_seq_chk.sv
module lin_hdr_seq_chk #(
    parameter int DW = 8
) (
    input logic          clk,
    input logic          rst,
    input logic          thr_wr,
    input logic          txrdy,
    input logic          tx_ovr,
    input logic          pl_vld,
    input logic          pl_rdy,
    input logic [DW-1:0] pl_data,
    input logic          frame_go,
    input logic [1:0]    fr_act,
    input logic          rx_vld,
    input logic          rxrdy,
    input logic          rhr_rd
);
    AST_ACCEPT_DROPS_RDY: assert property (@(posedge clk) disable iff (rst) (thr_wr && txrdy) |=> !txrdy); // R2
    AST_BLOCKED_WR_OVR: assert property (@(posedge clk) disable iff (rst) (thr_wr && !txrdy) |=> tx_ovr); // R3
    AST_OVR_STICKY: assert property (@(posedge clk) disable iff (rst) tx_ovr |=> tx_ovr); // R3
    AST_GO_ONE_CYCLE: assert property (@(posedge clk) disable iff (rst) frame_go |=> !frame_go); // R5
    AST_PL_HELD: assert property (@(posedge clk) disable iff (rst) (pl_vld && !pl_rdy) |=> (pl_vld && $stable(pl_data))); // R6
    AST_SUB_HOLDS_TX: assert property (@(posedge clk) disable iff (rst) (frame_go && fr_act == 2'd1) |-> !txrdy); // R9
    AST_RX_KEEP: assert property (@(posedge clk) disable iff (rst) (rxrdy && !rhr_rd) |=> rxrdy); // R9
    AST_RX_DROPPED: assert property (@(posedge clk) disable iff (rst) (rx_vld && txrdy && !rxrdy) |=> !rxrdy); // R10
endmodule

bind lin_hdr_seq lin_hdr_seq_chk #(.DW(DW)) u_chk (
    .clk      (clk),
    .rst      (rst),
    .thr_wr   (thr_wr),
    .txrdy    (txrdy),
    .tx_ovr   (tx_ovr),
    .pl_vld   (pl_vld),
    .pl_rdy   (pl_rdy),
    .pl_data  (pl_data),
    .frame_go (frame_go),
    .fr_act   (fr_act),
    .rx_vld   (rx_vld),
    .rxrdy    (rxrdy),
    .rhr_rd   (rhr_rd)
);

// File: tb/lin_hdr_seq_bench.sv
`timescale 1ns/1ps
module lin_hdr_seq_bench;
    localparam int CLK_P = 10;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       cfg_dma_en = 1'b1;
    logic [7:0] sw_mode = 8'h00, sw_dlc = 8'h00, sw_ident = 8'h00;
    logic       thr_wr = 1'b0;
    logic [7:0] thr_data = 8'h00;
    logic       txrdy, tx_ovr, pl_vld, frame_go, rxrdy;
    logic [7:0] pl_data, fr_dlc, fr_ident, rhr_data;
    logic       pl_rdy = 1'b1;
    logic [1:0] fr_act;
    logic       fr_pardis, fr_chkdis, fr_chktyp, fr_dlm, fr_fsdis;
    logic       rx_vld = 1'b0;
    logic [7:0] rx_data = 8'h00;
    logic       rhr_rd = 1'b0;

    int total = 0;
    int bad = 0;
    int popped = 0;
    logic [7:0] exp_q[$];

    always #(CLK_P/2) clk = ~clk;

    lin_hdr_seq u_lin_hdr_seq (
        .clk(clk), .rst(rst), .cfg_dma_en(cfg_dma_en),
        .sw_mode(sw_mode), .sw_dlc(sw_dlc), .sw_ident(sw_ident),
        .thr_wr(thr_wr), .thr_data(thr_data), .txrdy(txrdy), .tx_ovr(tx_ovr),
        .pl_vld(pl_vld), .pl_data(pl_data), .pl_rdy(pl_rdy),
        .frame_go(frame_go), .fr_act(fr_act), .fr_pardis(fr_pardis),
        .fr_chkdis(fr_chkdis), .fr_chktyp(fr_chktyp), .fr_dlm(fr_dlm),
        .fr_fsdis(fr_fsdis), .fr_dlc(fr_dlc), .fr_ident(fr_ident),
        .rx_vld(rx_vld), .rx_data(rx_data), .rxrdy(rxrdy),
        .rhr_data(rhr_data), .rhr_rd(rhr_rd)
    );

    task automatic check(input string tag, input int act, input int exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // Monitor: samples late in the low phase, after the driver has settled
    always begin
        @(negedge clk);
        #(CLK_P/4);
        if (!rst && pl_vld && pl_rdy) begin
            total++;
            if (exp_q.size() == 0) begin
                bad++;
                $display("FAIL R6 actual=%0h expected=none", pl_data);
            end else begin
                logic [7:0] e;
                e = exp_q.pop_front();
                popped++;
                if (pl_data !== e) begin
                    bad++;
                    $display("FAIL R6 actual=%0h expected=%0h", pl_data, e);
                end
            end
        end
    end

    task automatic put(input logic [7:0] b);
        while (!txrdy) @(negedge clk);
        thr_wr = 1'b1;
        thr_data = b;
        @(negedge clk);
        thr_wr = 1'b0;
    endtask

    task automatic put_pl(input logic [7:0] b);
        exp_q.push_back(b);
        put(b);
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    initial begin
        #(CLK_P * 150000);
        bad++;
        total++;
        $display("FAIL watchdog actual=running expected=finished");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        int base;
        idle(3);
        rst = 1'b0;
        @(negedge clk);
        // R1 reset state
        check("R1 txrdy", txrdy, 1);
        check("R1 tx_ovr", tx_ovr, 0);
        check("R1 pl_vld", pl_vld, 0);
        check("R1 frame_go", frame_go, 0);
        check("R1 rxrdy", rxrdy, 0);

        // DMA publish: pardis + chktyp, dlc 2
        put(8'h14);
        check("R2 txrdy low after accept", txrdy, 0);
        @(negedge clk);
        check("R2 txrdy back", txrdy, 1);
        put(8'h02);
        @(negedge clk);
        put(8'h3C);
        @(negedge clk);
        check("R5 frame_go", frame_go, 1);
        check("R4 act", fr_act, 0);
        check("R4 pardis", fr_pardis, 1);
        check("R4 chktyp", fr_chktyp, 1);
        check("R4 chkdis", fr_chkdis, 0);
        check("R4 dlc", fr_dlc, 8'h02);
        check("R5 ident", fr_ident, 8'h3C);
        put_pl(8'hA0);
        put_pl(8'hA1);
        put_pl(8'hA2);
        idle(3);
        check("R6 payload count", popped, 3);
        check("R6 queue drained", exp_q.size(), 0);

        // R6 next byte is configuration byte 1 again
        put(8'h00);
        put(8'h00);
        put(8'h55);
        @(negedge clk);
        check("R6 new frame_go", frame_go, 1);
        check("R6 new ident", fr_ident, 8'h55);
        put_pl(8'h77);
        idle(3);
        check("R6 single payload", popped, 4);

        // R7 ignore frame with frame-slot disable, sw ident
        sw_ident = 8'h2A;
        put(8'h42);
        put(8'h05);
        @(negedge clk);
        check("R7 frame_go", frame_go, 1);
        check("R7 act", fr_act, 2);
        check("R4 fsdis", fr_fsdis, 1);
        check("R7 ident from sw", fr_ident, 8'h2A);
        check("R7 dlc", fr_dlc, 8'h05);
        put(8'h02);
        put(8'h00);
        @(negedge clk);
        check("R7 back to byte 1", frame_go, 1);
        idle(2);
        check("R7 no payload", popped, 4);

        // R9 subscribe with chkdis, dlc 1
        put(8'h09);
        put(8'h01);
        @(negedge clk);
        check("R9 frame_go", frame_go, 1);
        check("R9 act", fr_act, 1);
        check("R4 chkdis", fr_chkdis, 1);
        check("R9 txrdy held", txrdy, 0);
        rx_vld = 1'b1; rx_data = 8'hB1;
        @(negedge clk);
        rx_vld = 1'b0;
        check("R9 rxrdy", rxrdy, 1);
        check("R9 rhr", rhr_data, 8'hB1);
        check("R9 txrdy still held", txrdy, 0);
        rx_vld = 1'b1; rx_data = 8'hB2; rhr_rd = 1'b1;
        @(negedge clk);
        rx_vld = 1'b0; rhr_rd = 1'b0;
        check("R9 rxrdy kept on same-cycle arrival", rxrdy, 1);
        check("R9 rhr new byte", rhr_data, 8'hB2);
        check("R9 txrdy after last rx", txrdy, 1);
        rhr_rd = 1'b1;
        @(negedge clk);
        rhr_rd = 1'b0;
        check("R9 read clears", rxrdy, 0);

        // R10 stray receive byte
        rx_vld = 1'b1; rx_data = 8'hEE;
        @(negedge clk);
        rx_vld = 1'b0;
        @(negedge clk);
        check("R10 rxrdy stays 0", rxrdy, 0);
        check("R10 rhr unchanged", rhr_data, 8'hB2);

        // R8 software configuration
        cfg_dma_en = 1'b0;
        sw_mode = 8'h20;
        sw_dlc = 8'h01;
        put(8'h15);
        @(negedge clk);
        check("R8 frame_go", frame_go, 1);
        check("R8 dlm", fr_dlm, 1);
        check("R8 act", fr_act, 0);
        check("R8 dlc", fr_dlc, 8'h01);
        check("R8 ident", fr_ident, 8'h15);
        put_pl(8'h61);
        put_pl(8'h62);
        idle(3);
        check("R8 payload count", popped, 6);
        cfg_dma_en = 1'b1;

        // R3 blocked write during a stalled payload byte
        put(8'h00);
        put(8'h00);
        put(8'h11);
        @(negedge clk);
        pl_rdy = 1'b0;
        put_pl(8'h99);
        check("R3 txrdy low in stall", txrdy, 0);
        check("R3 ovr clear", tx_ovr, 0);
        thr_wr = 1'b1; thr_data = 8'hBB;
        @(negedge clk);
        thr_wr = 1'b0;
        @(negedge clk);
        check("R3 ovr set", tx_ovr, 1);
        check("R3 stalled byte kept", pl_data, 8'h99);
        check("R6 pl_vld held", pl_vld, 1);
        base = popped;
        pl_rdy = 1'b1;
        idle(3);
        check("R3 one byte out", popped, base + 1);
        check("R3 ovr sticky", tx_ovr, 1);
        put(8'h00);
        put(8'h00);
        put(8'h44);
        @(negedge clk);
        check("R3 dropped byte not in header", fr_ident, 8'h44);
        put_pl(8'h45);
        idle(3);
        check("R3 queue drained", exp_q.size(), 0);

        // R1 reset clears overrun
        rst = 1'b1;
        idle(2);
        rst = 1'b0;
        @(negedge clk);
        check("R1 ovr cleared", tx_ovr, 0);
        check("R1 txrdy after reset", txrdy, 1);

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule